// File: doc/BRIEF.md
# Wide-Word Pin Capture Packer

This block records the state of a group of input pins into shared memory at high rate. Each time the capture is running and the sample-enable tick is high, every selected pin is registered on the same clock edge, and the sample is placed into the next free lane of a 256-bit assembly word. The sample width can be 32, 64 or 128 bits, so one wide word holds 8, 4 or 2 samples. When the last lane fills, the word is offered on a write stream together with a word address. The address starts at zero for each capture, advances by one per accepted write, and wraps after a configurable last address.

The write stream uses valid/ready. The block raises `wr_valid` with the data and address, and holds all three unchanged until `wr_ready` is seen high on a clock edge. Sampling continues during that wait into the next word. Only one completed word can wait. If the following word completes while the earlier one is still not accepted, the new word is thrown away, the overflow status is set and capture stops. The word that was waiting stays offered. An optional mode stops the capture once the write to the last address is accepted, so the start of the buffer is never overwritten. A stop request ends the capture at once. A partly filled word is never written, and the number of samples it held is reported.

Top module: `wide_pin_sampler`

## Requirements
- R1: `wmode` selects the sample width when the capture starts: 2'b00 gives 32 bits (8 samples per word), 2'b01 gives 64 bits (4 per word), and 2'b10 or 2'b11 give 128 bits (2 per word). A sample is the low W bits of `pins`.
- R2: Sample k of a word, counting from 0 at the first sample after the previous word, occupies `wr_data[k*W +: W]`. Samples fill from the least significant lane upward.
- R3: A sample is taken only on a clock edge where `busy` and `tick` are both high. There is at most one sample per edge. All pins in a sample come from that one edge.
- R4: `wr_valid` rises on the same edge that captures the last sample of a word. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_data` and `wr_addr` stay unchanged. A write is accepted on an edge where both are high.
- R5: After a start, the first word goes to address 0. Each accepted write advances the address by one. The address after `ptr_limit` is 0.
- R6: If `wrap_stop` was high at start, acceptance of the write to address `ptr_limit` clears `busy` and sets `wrapped`. No further write follows, and a word that completes on that same edge is discarded.
- R7: If a word completes on an edge where `wr_valid` is high and `wr_ready` is low, that word is discarded. On the same edge `overflow` is set and `busy` clears, and the waiting write stays valid until accepted.
- R8: `stop` high while busy clears `busy` on the next edge and takes priority over a `tick` in the same cycle. The partial word is not written, and `part_cnt` takes the number of samples it held (0 if none).
- R9: `start` is taken only while `busy` and `wr_valid` are both low. It sets `busy`, clears `overflow`, `wrapped` and `part_cnt`, empties the word, and latches `wmode` and `wrap_stop`. A `start` while busy has no effect, and a changed `wmode` is not picked up.
- R10: After reset, `wr_valid`, `busy`, `overflow`, `wrapped` and `part_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | 128 | Pin group to be sampled |
| tick | input | 1 | Sample enable from a prescaler or counter |
| start | input | 1 | Begin a capture (accepted when idle) |
| stop | input | 1 | End the capture |
| wmode | input | 2 | Sample width select |
| wrap_stop | input | 1 | Stop after the write to the last address |
| ptr_limit | input | 10 | Last word address before wrap to 0 |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_data | output | 256 | Packed wide word |
| wr_addr | output | 10 | Word address of the write |
| busy | output | 1 | Capture running |
| overflow | output | 1 | A word was lost to back-pressure |
| wrapped | output | 1 | Capture ended at the pointer wrap |
| part_cnt | output | 4 | Samples left in the unwritten word at stop |

## Verification
Assertions check on every cycle that a pending write holds its data under back-pressure and that the pointer only steps by one or returns to zero. They also check that the fill count stays inside the current word, that a completed word meeting an unaccepted write ends in overflow, that a stop ends capture, and that an accepted write at the last address in wrap-stop mode ends capture. Only the bench scenarios can show that each sample lands in the right lane for every width, that gaps in the tick are skipped, and that the address sequence wraps correctly. The same holds for the exact partial count after a stop that collides with a tick, and for a start during a run leaving the width unchanged.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef enum logic [1:0] {
    SW_32   = 2'b00,
    SW_64   = 2'b01,
    SW_128  = 2'b10,
    SW_128B = 2'b11
  } samp_width_e;

  // log2 of the number of 32-bit lanes one sample covers
  function automatic logic [1:0] lane_shift(samp_width_e m);
    case (m)
      SW_32:   return 2'd0;
      SW_64:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/sample_packer.sv
module sample_packer #(
  parameter int LANE_W    = 32,
  parameter int LANES     = 8,
  parameter int PIN_LANES = 4,
  parameter int FILL_W    = $clog2(LANES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        cap_en,
  input  logic [1:0]                  shift,
  input  logic [PIN_LANES*LANE_W-1:0] pins,
  output logic [LANES*LANE_W-1:0]     word_next,
  output logic [FILL_W-1:0]           fill,
  output logic                        last
);
  localparam int SEL_W = (PIN_LANES > 1) ? $clog2(PIN_LANES) : 1;

  logic [LANE_W-1:0] pin_lane [PIN_LANES];
  logic [FILL_W-1:0] spw_m1;

  for (genvar j = 0; j < PIN_LANES; j++) begin : g_pin
    assign pin_lane[j] = pins[j*LANE_W +: LANE_W];
  end

  assign spw_m1 = FILL_W'((LANES >> shift) - 1);
  assign last   = (fill == spw_m1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    logic              hit;
    logic [SEL_W-1:0]  sel;
    always_comb begin
      hit = cap_en && (FILL_W'(i >> shift) == fill);
      sel = SEL_W'(i & ((1 << shift) - 1));
    end
    assign word_next[i*LANE_W +: LANE_W] = hit ? pin_lane[sel] : lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= word_next[i*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fill <= '0;
    else if (clr)    fill <= '0;
    else if (cap_en) fill <= last ? '0 : fill + FILL_W'(1);
  end

  // R2
  fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= spw_m1);

endmodule

// File: rtl/wide_wr_port.sv
module wide_wr_port #(
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] dout,
  output logic              free,
  output logic              acc
);
  assign acc  = valid && ready;
  assign free = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (acc) begin
      valid <= 1'b0;
    end
  end

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(dout));

endmodule

// File: rtl/wrap_ptr.sv
module wrap_ptr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] ptr,
  output logic              at_limit
);
  assign at_limit = (ptr == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (clr) ptr <= '0;
    else if (adv) ptr <= at_limit ? '0 : ptr + ADDR_W'(1);
  end

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !clr |=> (ptr == '0) || (ptr == $past(ptr) + ADDR_W'(1)));

endmodule

// File: rtl/wide_pin_sampler.sv
module wide_pin_sampler
  import wps_pkg::*;
#(
  parameter  int LANE_W = 32,
  parameter  int WORD_W = 256,
  parameter  int ADDR_W = 10,
  localparam int LANES  = WORD_W / LANE_W,
  localparam int PIN_W  = 4 * LANE_W,
  localparam int FILL_W = $clog2(LANES),
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  pins,
  input  logic              tick,
  input  logic              start,
  input  logic              stop,
  input  logic [1:0]        wmode,
  input  logic              wrap_stop,
  input  logic [ADDR_W-1:0] ptr_limit,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              busy,
  output logic              overflow,
  output logic              wrapped,
  output logic [CNT_W-1:0]  part_cnt
);
  samp_width_e       mode_q;
  logic              wrap_q;
  logic              start_ok, cap_en, load, drop, wrap_hit;
  logic              wr_free, wr_acc, last, at_limit;
  logic [FILL_W-1:0] fill;
  logic [WORD_W-1:0] word_next;

  assign start_ok = start && !busy && !wr_valid;
  assign cap_en   = busy && tick && !stop;
  assign wrap_hit = wr_acc && at_limit && wrap_q;
  assign load     = cap_en && last && wr_free && !wrap_hit;
  assign drop     = cap_en && last && !wr_free;

  sample_packer #(
    .LANE_W(LANE_W), .LANES(LANES), .PIN_LANES(4), .FILL_W(FILL_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .cap_en(cap_en),
    .shift(lane_shift(mode_q)), .pins(pins),
    .word_next(word_next), .fill(fill), .last(last)
  );

  wide_wr_port #(.DATA_W(WORD_W)) u_port (
    .clk(clk), .rst_n(rst_n), .load(load), .din(word_next),
    .ready(wr_ready), .valid(wr_valid), .dout(wr_data),
    .free(wr_free), .acc(wr_acc)
  );

  wrap_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .adv(wr_acc),
    .limit(ptr_limit), .ptr(wr_addr), .at_limit(at_limit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      overflow <= 1'b0;
      wrapped  <= 1'b0;
      part_cnt <= '0;
      mode_q   <= SW_32;
      wrap_q   <= 1'b0;
    end else if (start_ok) begin
      busy     <= 1'b1;
      overflow <= 1'b0;
      wrapped  <= 1'b0;
      part_cnt <= '0;
      mode_q   <= samp_width_e'(wmode);
      wrap_q   <= wrap_stop;
    end else begin
      if (busy && stop) begin
        busy     <= 1'b0;
        part_cnt <= CNT_W'(fill);
      end
      if (drop) begin
        busy     <= 1'b0;
        overflow <= 1'b1;
      end
      if (wrap_hit) begin
        busy    <= 1'b0;
        wrapped <= 1'b1;
      end
    end
  end

  // R7
  ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en && last && wr_valid && !wr_ready |=> overflow && !busy && wr_valid);

  // R8
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && stop |=> !busy);

  // R6
  wrap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_addr == ptr_limit && wrap_q |=> !busy && !wr_valid);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> $stable(wr_addr));

endmodule

// File: tb/sim_wide_pin_sampler.sv
`timescale 1ns/100ps
module sim_wide_pin_sampler;
  localparam int AW = 10;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [127:0]  pins = '0;
  logic          tick = 1'b0, start = 1'b0, stop = 1'b0;
  logic [1:0]    wmode = 2'b00;
  logic          wrap_stop = 1'b0;
  logic [AW-1:0] ptr_limit = AW'(15);
  logic          wr_valid, wr_ready = 1'b1;
  logic [255:0]  wr_data;
  logic [AW-1:0] wr_addr;
  logic          busy, overflow, wrapped;
  logic [3:0]    part_cnt;

  wide_pin_sampler u0 (
    .clk(clk), .rst_n(rst_n), .pins(pins), .tick(tick), .start(start),
    .stop(stop), .wmode(wmode), .wrap_stop(wrap_stop), .ptr_limit(ptr_limit),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_addr(wr_addr), .busy(busy), .overflow(overflow), .wrapped(wrapped),
    .part_cnt(part_cnt)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [AW+255:0] exp_q[$];

  // bench model
  logic          m_busy = 0, m_drop = 0, m_wrap = 0;
  int            m_w = 32, m_fill = 0;
  logic [AW-1:0] m_ptr = '0, m_lim = '0;
  logic [255:0]  m_word = '0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: samples just before the edge that uses the handshake
  always begin
    @(negedge clk); #1.5;
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R4 unexpected write", 64'(wr_addr), 64'hFFFF);
      end else begin
        logic [AW+255:0] e;
        e = exp_q.pop_front();
        check(wr_addr == e[AW+255:256], "R5 address", 64'(wr_addr), 64'(e[AW+255:256]));
        check(wr_data == e[255:0], "R2 data", wr_data[63:0], e[63:0]);
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  task automatic smp(input logic [127:0] v, input bit with_tick = 1);
    @(negedge clk); #1;
    tick = with_tick; pins = v;
    if (with_tick && m_busy) begin
      for (int b = 0; b < m_w; b++) m_word[m_fill*m_w + b] = v[b];
      m_fill++;
      if (m_fill == 256 / m_w) begin
        m_fill = 0;
        if (m_drop) m_busy = 0;
        else begin
          exp_q.push_back({m_ptr, m_word});
          if (m_wrap && m_ptr == m_lim) m_busy = 0;
          m_ptr = (m_ptr == m_lim) ? '0 : m_ptr + 1'b1;
        end
      end
    end
    @(negedge clk); #1;
    tick = 0;
  endtask

  function automatic logic [127:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic do_start(input logic [1:0] m, input bit wr, input logic [AW-1:0] lim);
    @(negedge clk); #1;
    start = 1; wmode = m; wrap_stop = wr; ptr_limit = lim;
    m_busy = 1; m_fill = 0; m_ptr = '0; m_lim = lim; m_wrap = wr;
    m_w = (m == 2'b00) ? 32 : (m == 2'b01) ? 64 : 128;
    @(negedge clk); #1;
    start = 0;
  endtask

  task automatic do_stop(input bit with_tick);
    @(negedge clk); #1;
    stop = 1; tick = with_tick; pins = rnd();
    m_busy = 0;
    @(negedge clk); #1;
    stop = 0; tick = 0;
  endtask

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R10 reset state
    check(!wr_valid && !busy && !overflow && !wrapped && part_cnt == 0, "R10 reset",
          {wr_valid, busy, overflow, wrapped, part_cnt}, 0);
    rst_n = 1;
    wait_cyc(2);

    // R1 R2 R5: 32-bit samples, back-to-back ticks, three words
    do_start(2'b00, 0, AW'(15));
    check(busy, "R9 busy after start", 64'(busy), 1);
    for (int k = 0; k < 24; k++) smp(rnd());
    wait_cyc(4);
    check(exp_q.size() == 0, "R4 32-bit words written", exp_q.size(), 0);
    do_stop(0);
    check(part_cnt == 0, "R8 empty partial", 64'(part_cnt), 0);

    // R3: 64-bit samples with idle gaps in the tick
    wait_cyc(2);
    do_start(2'b01, 0, AW'(15));
    for (int k = 0; k < 8; k++) begin smp(rnd()); smp(rnd(), 0); end
    wait_cyc(4);
    check(exp_q.size() == 0, "R3 64-bit words with gaps", exp_q.size(), 0);
    do_stop(0);

    // R1: 128-bit via code 2'b11, then back-pressure R4
    wait_cyc(2);
    do_start(2'b11, 0, AW'(15));
    for (int k = 0; k < 4; k++) smp(rnd());
    wait_cyc(3);
    wr_ready = 0;
    smp(rnd()); smp(rnd());
    wait_cyc(5);
    check(wr_valid, "R4 valid held under back-pressure", 64'(wr_valid), 1);
    check(exp_q.size() == 1, "R4 not taken while stalled", exp_q.size(), 1);
    smp(rnd());
    wr_ready = 1;
    smp(rnd());
    wait_cyc(4);
    check(exp_q.size() == 0, "R4 stalled words delivered", exp_q.size(), 0);
    check(!overflow, "R7 no overflow", 64'(overflow), 0);
    do_stop(0);

    // R8: partial word, stop collides with tick
    wait_cyc(2);
    do_start(2'b00, 0, AW'(15));
    for (int k = 0; k < 3; k++) smp(rnd());
    do_stop(1);
    wait_cyc(3);
    check(!busy, "R8 busy cleared", 64'(busy), 0);
    check(part_cnt == 3, "R8 partial count", 64'(part_cnt), 3);
    check(!wr_valid && exp_q.size() == 0, "R8 partial not written", 64'(wr_valid), 0);

    // R9: start while busy is ignored
    do_start(2'b00, 0, AW'(15));
    check(part_cnt == 0, "R9 status cleared", 64'(part_cnt), 0);
    for (int k = 0; k < 3; k++) smp(rnd());
    @(negedge clk); #1; start = 1; wmode = 2'b10;
    @(negedge clk); #1; start = 0;
    for (int k = 0; k < 5; k++) smp(rnd());
    wait_cyc(4);
    check(exp_q.size() == 0, "R9 width kept", exp_q.size(), 0);
    check(busy, "R9 still busy", 64'(busy), 1);
    do_stop(0);

    // R7: overflow
    wait_cyc(2);
    do_start(2'b10, 0, AW'(15));
    wr_ready = 0;
    smp(rnd()); smp(rnd());
    m_drop = 1;
    smp(rnd()); smp(rnd());
    wait_cyc(2);
    check(overflow, "R7 overflow set", 64'(overflow), 1);
    check(!busy, "R7 capture stopped", 64'(busy), 0);
    check(wr_valid, "R7 pending write kept", 64'(wr_valid), 1);
    m_drop = 0;
    wr_ready = 1;
    wait_cyc(4);
    check(exp_q.size() == 0 && !wr_valid, "R7 pending word delivered", exp_q.size(), 0);

    // R6: wrap with cancel, limit 2
    do_start(2'b10, 1, AW'(2));
    for (int k = 0; k < 10; k++) smp(rnd());
    wait_cyc(4);
    check(wrapped, "R6 wrapped set", 64'(wrapped), 1);
    check(!busy, "R6 capture stopped", 64'(busy), 0);
    check(exp_q.size() == 0, "R6 three words only", exp_q.size(), 0);

    // R5: wrap without cancel, limit 1
    do_start(2'b10, 0, AW'(1));
    for (int k = 0; k < 6; k++) smp(rnd());
    wait_cyc(4);
    check(!wrapped && busy, "R5 runs past wrap", {wrapped, busy}, 1);
    check(exp_q.size() == 0, "R5 addresses 0,1,0", exp_q.size(), 0);
    do_stop(0);
    wait_cyc(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule